// File: doc/BRIEF.md
# Event Down Counter Channel

This block is a single timer channel that counts external events downward. An asynchronous event pin is brought into the clock domain by a synchronizer. A configurable edge detector then turns selected transitions of the pin into one-clock count strobes. While the channel runs, each strobe lowers a count register by one. A strobe that arrives while the count is zero reloads the count from a data register and raises a single-cycle interrupt. Counting then carries on with no software involvement.

Software controls the channel through a small word-wide register port: a reload value, an edge-mode field, and a control word whose start and stop bits act as self-clearing triggers. The running state is visible on a status output, and the live count can be read at any time. A unit-level clock enable returns the whole channel to its reset state while low, and blocks all writes during that time.

Top module: `evtcnt_channel`

## Requirements
- R1: After reset, and on the clock after any cycle in which `unit_en` is low, the count, reload value and mode are zero, `running` is 0 and `irq` is 0. Writes made while `unit_en` is low have no effect.
- R2: Writing a word with bit 0 set to address 2 sets `running` and copies the reload value into the count. Address 2 always reads back as zero.
- R3: Writing a word with bit 1 set to address 2 clears `running`, and the count keeps its value. When bits 0 and 1 are both set, the stop wins.
- R4: While running, each count strobe lowers the count by exactly one. Strobes while stopped leave the count unchanged.
- R5: A strobe that finds the count at zero loads the reload value into the count and drives `irq` high for exactly one cycle. That is the same cycle in which the reloaded count first appears.
- R6: Mode bits [1:0] pick the counted edge: 0 counts rising edges, 1 counts falling edges, 2 counts both, and 3 counts none.
- R7: The reload value (address 0) may be written while running. The new value changes the count only at the next reload.
- R8: A write to the mode register (address 1) while `running` is 1 is ignored.
- R9: A pin transition applied between clock edges changes the count on the third rising clock edge that follows, and not before.
- R10: Reads are combinational from `rd_addr`: 0 returns the reload value, 1 returns the mode zero-extended, 2 returns zero, and 3 returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Unit clock enable; low clears the channel and blocks writes |
| evt_in | input | 1 | Asynchronous event pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | CNT_W (16) | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | CNT_W (16) | Read data |
| running | output | 1 | Channel enable status |
| irq | output | 1 | One-cycle reload interrupt |

## Verification
The properties assume that at most one register write occurs per clock and that the start and stop triggers arrive only through the address-2 write. They also assume that the event pin may change at any time, because the synchronizer absorbs that. The stimulus changes `evt_in` only on falling clock edges and holds each level for four cycles, so every transition yields exactly one strobe before the next one. A mode change is made only while the channel is stopped, so that each vector starts from a known edge mode. The reload-at-zero property relies on no start or stop write landing in the same cycle as a zero-count strobe. The bench keeps control writes apart from pin activity to hold that condition.

// File: rtl/evtcnt_pkg.sv
package evtcnt_pkg;

   localparam int ADDR_W = 2;

   typedef enum logic [1:0] {
      EDGE_RISE = 2'd0,
      EDGE_FALL = 2'd1,
      EDGE_BOTH = 2'd2,
      EDGE_NONE = 2'd3
   } edge_sel_e;

   typedef enum logic [ADDR_W-1:0] {
      REG_RELOAD = 2'd0,
      REG_MODE   = 2'd1,
      REG_CTRL   = 2'd2,
      REG_COUNT  = 2'd3
   } reg_addr_e;

   localparam int CTRL_START_BIT = 0;
   localparam int CTRL_STOP_BIT  = 1;

endpackage

// File: rtl/evtcnt_sync.sv
// Multi-stage level synchronizer for the event pin (R9 latency source).
module evtcnt_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("evtcnt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else if (clr) begin
         chain_q <= '0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], d};
      end
   end

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/evtcnt_edge.sv
// Edge detector producing a one-clock strobe for the selected edge type (R6).
module evtcnt_edge
   import evtcnt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr,
   input  logic      lvl,
   input  edge_sel_e sel,
   output logic      strobe
);

   logic prev_q;
   logic rise;
   logic fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
      end else if (clr) begin
         prev_q <= 1'b0;
      end else begin
         prev_q <= lvl;
      end
   end

   assign rise = lvl & ~prev_q;
   assign fall = ~lvl & prev_q;

   always_comb begin
      unique case (sel)
         EDGE_RISE: strobe = rise;
         EDGE_FALL: strobe = fall;
         EDGE_BOTH: strobe = rise | fall;
         default:   strobe = 1'b0;
      endcase
   end

endmodule

// File: rtl/evtcnt_regs.sv
// Register file: reload value, locked mode field, self-clearing triggers, read mux.
module evtcnt_regs
   import evtcnt_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_en,
   input  logic              running,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  cnt,
   output logic [CNT_W-1:0]  rd_data,
   output logic [CNT_W-1:0]  reload,
   output edge_sel_e         mode,
   output logic              start_req,
   output logic              stop_req
);

   logic ctrl_wr;

   assign ctrl_wr   = unit_en && wr_en && (wr_addr == REG_CTRL);
   assign start_req = ctrl_wr && wr_data[CTRL_START_BIT];
   assign stop_req  = ctrl_wr && wr_data[CTRL_STOP_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload <= '0;
         mode   <= EDGE_RISE;
      end else if (!unit_en) begin
         reload <= '0;
         mode   <= EDGE_RISE;
      end else if (wr_en) begin
         if (wr_addr == REG_RELOAD) begin
            reload <= wr_data;
         end
         if ((wr_addr == REG_MODE) && !running) begin
            mode <= edge_sel_e'(wr_data[1:0]);
         end
      end
   end

   always_comb begin
      unique case (rd_addr)
         REG_RELOAD: rd_data = reload;
         REG_MODE:   rd_data = CNT_W'(mode);
         REG_COUNT:  rd_data = cnt;
         default:    rd_data = '0;
      endcase
   end

endmodule

// File: rtl/evtcnt_core.sv
// Down counter with start load, stop freeze and reload-at-zero interrupt.
module evtcnt_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             unit_en,
   input  logic             start_req,
   input  logic             stop_req,
   input  logic             strobe,
   input  logic [CNT_W-1:0] reload,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             irq
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= CNT_ZERO;
         running <= 1'b0;
         irq     <= 1'b0;
      end else begin
         irq <= 1'b0;
         if (!unit_en) begin
            cnt     <= CNT_ZERO;
            running <= 1'b0;
         end else if (stop_req) begin
            running <= 1'b0;
         end else if (start_req) begin
            running <= 1'b1;
            cnt     <= reload;
         end else if (running && strobe) begin
            if (cnt == CNT_ZERO) begin
               cnt <= reload;
               irq <= 1'b1;
            end else begin
               cnt <= cnt - CNT_ONE;
            end
         end
      end
   end

endmodule

// File: rtl/evtcnt_channel.sv
// Top level: external event down counter channel.
module evtcnt_channel
   import evtcnt_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              unit_en,
   input  logic              evt_in,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [1:0]        rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   output logic              running,
   output logic              irq
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("evtcnt_channel: CNT_W must be in 2..32");
      end
   endgenerate

   logic             clr;
   logic             evt_sync;
   logic             strobe;
   logic             start_req;
   logic             stop_req;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   edge_sel_e        mode_q;

   assign clr = ~unit_en;

   evtcnt_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .d     (evt_in),
      .q     (evt_sync)
   );

   evtcnt_edge i_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .lvl    (evt_sync),
      .sel    (mode_q),
      .strobe (strobe)
   );

   evtcnt_regs #(.CNT_W(CNT_W)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .unit_en   (unit_en),
      .running   (running),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .rd_addr   (rd_addr),
      .cnt       (cnt_q),
      .rd_data   (rd_data),
      .reload    (reload_q),
      .mode      (mode_q),
      .start_req (start_req),
      .stop_req  (stop_req)
   );

   evtcnt_core #(.CNT_W(CNT_W)) i_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .unit_en   (unit_en),
      .start_req (start_req),
      .stop_req  (stop_req),
      .strobe    (strobe),
      .reload    (reload_q),
      .cnt       (cnt_q),
      .running   (running),
      .irq       (irq)
   );

endmodule

// File: rtl/evtcnt_channel_chk.sv
module evtcnt_channel_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             unit_en,
   input logic             wr_en,
   input logic [1:0]       wr_addr,
   input logic [CNT_W-1:0] wr_data,
   input logic             running,
   input logic             irq,
   input logic             strobe,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] reload,
   input logic [1:0]       mode
);

   logic ctrl_w;
   logic start_w;
   logic stop_w;

   assign ctrl_w  = wr_en && (wr_addr == 2'd2);
   assign start_w = ctrl_w && wr_data[0];
   assign stop_w  = ctrl_w && wr_data[1];

   // R1: gating the unit clears the channel on the next clock
   a_r1_gated_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !unit_en |=> (!running && (cnt == '0) && !irq));

   // R2: start loads the reload value and enables the channel
   a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && start_w && !stop_w) |=> (running && (cnt == $past(reload))));

   // R3: stop clears the enable flag
   a_r3_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && stop_w) |=> !running);

   // R3: a stopped channel holds its count unless started
   a_r3_stop_freezes: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && !running && !start_w) |=> $stable(cnt));

   // R4: one strobe lowers a nonzero count by one
   a_r4_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && running && strobe && (cnt != '0) && !ctrl_w)
         |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

   // R5: interrupt appears together with the reloaded count
   a_r5_irq_reload: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ($past(running) && (cnt == $past(reload))));

   // R8: mode is frozen while the channel runs
   a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      (unit_en && running) |=> $stable(mode));

endmodule

bind evtcnt_channel evtcnt_channel_chk #(.CNT_W(CNT_W)) i_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .unit_en (unit_en),
   .wr_en   (wr_en),
   .wr_addr (wr_addr),
   .wr_data (wr_data),
   .running (running),
   .irq     (irq),
   .strobe  (strobe),
   .cnt     (cnt_q),
   .reload  (reload_q),
   .mode    (mode_q)
);

// File: tb/test_evtcnt_channel.sv
module test_evtcnt_channel;

   localparam int W = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          unit_en = 1'b1;
   logic          evt_in = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = '0;
   logic [W-1:0]  wr_data = '0;
   logic [1:0]    rd_addr = '0;
   logic [W-1:0]  rd_data;
   logic          running;
   logic          irq;

   int checks = 0;
   int errors = 0;
   int irq_cnt = 0;
   int irq_run = 0;
   int irq_run_max = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   evtcnt_channel #(.CNT_W(W)) i_evtcnt_channel (
      .clk     (clk),
      .rst_n   (rst_n),
      .unit_en (unit_en),
      .evt_in  (evt_in),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .running (running),
      .irq     (irq)
   );

   always @(negedge clk) begin
      if (irq) begin
         irq_cnt = irq_cnt + 1;
         irq_run = irq_run + 1;
         if (irq_run > irq_run_max) irq_run_max = irq_run;
      end else begin
         irq_run = 0;
      end
   end

   // {mode[1:0], reload[15:0], pulses[7:0]}
   localparam logic [25:0] VEC [0:7] = '{
      {2'd0, 16'd5,      8'd3},
      {2'd0, 16'd2,      8'd3},
      {2'd1, 16'd4,      8'd7},
      {2'd2, 16'd3,      8'd5},
      {2'd3, 16'd6,      8'd4},
      {2'd0, 16'd0,      8'd3},
      {2'd2, 16'hFFFF,   8'd2},
      {2'd1, 16'd1,      8'd4}
   };

   task automatic finish_sim();
      if (!finished) begin
         finished = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks = checks + 1;
      if (act !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [W-1:0] v);
      rd_addr = a;
      #1;
      v = rd_data;
   endtask

   task automatic pulse();
      @(negedge clk);
      evt_in = 1'b1;
      repeat (4) @(negedge clk);
      evt_in = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   function automatic int edges_per_pulse(logic [1:0] m);
      case (m)
         2'd0, 2'd1: return 1;
         2'd2:       return 2;
         default:    return 0;
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      errors = errors + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_sim();
   end

   initial begin
      logic [W-1:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R10: reset state
      check("R1 running after reset", running, 0);
      check("R1 irq after reset", irq, 0);
      rd(2'd0, v); check("R1 reload after reset", v, 0);
      rd(2'd3, v); check("R1 count after reset", v, 0);

      // Vector table: R4, R5, R6
      for (int i = 0; i < 8; i++) begin
         logic [1:0]  m;
         logic [15:0] l;
         int          p;
         int          k;
         m = VEC[i][25:24];
         l = VEC[i][23:8];
         p = int'(VEC[i][7:0]);
         wr(2'd2, 16'h0002);
         wr(2'd1, 16'(m));
         wr(2'd0, l);
         irq_cnt = 0;
         wr(2'd2, 16'h0001);
         check("R2 running after start", running, 1);
         rd(2'd3, v); check("R2 count loaded at start", v, l);
         for (int j = 0; j < p; j++) pulse();
         k = p * edges_per_pulse(m);
         rd(2'd3, v);
         check("R4 R6 count after events", v, 32'(int'(l) - (k % (int'(l) + 1))));
         check("R5 irq count", irq_cnt, k / (int'(l) + 1));
      end
      check("R5 irq single cycle", irq_run_max, 1);

      // R10: mode readback and control reads zero
      rd(2'd1, v); check("R10 mode readback", v, 1);
      rd(2'd2, v); check("R2 R10 control reads zero", v, 0);

      // R8: mode write while running ignored
      wr(2'd1, 16'h0002);
      rd(2'd1, v); check("R8 mode locked while running", v, 1);

      // R3: stop freezes, edges while stopped ignored
      wr(2'd2, 16'h0002);
      wr(2'd1, 16'h0000);
      wr(2'd0, 16'd10);
      wr(2'd2, 16'h0001);
      pulse(); pulse();
      rd(2'd3, v); check("R4 count after two edges", v, 8);
      wr(2'd2, 16'h0002);
      check("R3 stopped", running, 0);
      pulse(); pulse();
      rd(2'd3, v); check("R3 R4 count frozen when stopped", v, 8);
      rd(2'd1, v); check("R8 mode accepted when stopped", v, 0);

      // R3: stop wins over start
      wr(2'd2, 16'h0003);
      check("R3 stop wins over start", running, 0);

      // R7: reload rewritten while running
      wr(2'd0, 16'd3);
      wr(2'd2, 16'h0001);
      wr(2'd0, 16'd9);
      rd(2'd3, v); check("R7 count unaffected by data write", v, 3);
      pulse(); pulse(); pulse();
      rd(2'd3, v); check("R7 count reached zero", v, 0);
      irq_cnt = 0;
      pulse();
      rd(2'd3, v); check("R7 new reload used", v, 9);
      check("R5 irq on reload", irq_cnt, 1);

      // R9: latency of three clock edges
      rd_addr = 2'd3;
      @(negedge clk);
      evt_in = 1'b1;
      @(posedge clk); @(posedge clk);
      @(negedge clk); rd(2'd3, v); check("R9 no change after two edges", v, 9);
      @(posedge clk);
      @(negedge clk); rd(2'd3, v); check("R9 change on third edge", v, 8);
      evt_in = 1'b0;
      repeat (4) @(negedge clk);

      // R1: unit gating
      unit_en = 1'b0;
      @(negedge clk);
      check("R1 running cleared by gating", running, 0);
      rd(2'd3, v); check("R1 count cleared by gating", v, 0);
      wr(2'd0, 16'd7);
      rd(2'd0, v); check("R1 write blocked while gated", v, 0);
      wr(2'd2, 16'h0001);
      check("R1 start blocked while gated", running, 0);
      unit_en = 1'b1;
      @(negedge clk);
      rd(2'd0, v); check("R1 reload still zero", v, 0);

      finish_sim();
   end

endmodule